// File: doc/BRIEF.md
# Carry-Save Array Multiplier

This block multiplies two unsigned operands and returns the full-width product. It is purely combinational: the product follows the operands with no clock, reset or handshake. It is meant for a datapath that needs a complete unsigned product within a single cycle, with the product register supplied by the enclosing logic.

Inside, a grid of AND gates builds one shifted partial-product row for each multiplier bit. Rows of full adders, each used as a three-input, two-output counter, fold one partial product at a time into a pair of vectors: a sum vector and a carry vector. No carry travels along a row. Each carry moves one column to the left and enters the next row, so the delay of a row does not grow with operand width. One carry-propagating ripple adder at the end resolves the last sum and carry vectors into the product.

Top module: `csa_array_mult`

## Requirements
- R1: For every pair of unsigned 8-bit operands, `p` equals the arithmetic product `a*b`, with all 16 bits kept.
- R2: Partial-product bit (i,j) is `a[i] & b[j]`, weighted by 2^(i+j). A clear multiplier bit contributes nothing, so `b = 0` gives `p = 0` and `b = 2^j` gives `p = a << j`.
- R3: Each reduction cell is a full adder whose two outputs, read as {carry,sum}, give the count of ones on its three inputs.
- R4: A carry-save row adds each column on its own and keeps sum and carry separate. The carry from column k enters column k+1 of the next stage, and the row keeps the total value of its three inputs.
- R5: One ripple adder, with a carry-in of 0, merges the final sum and carry vectors. Its sum equals their exact total and no carry leaves its top bit.
- R6: No product bit is truncated. 255 × 255 gives 16'hFE01, and 255 × 1 gives 16'h00FF.
- R7: The block has no clock or state. A new operand pair shows on `p` within the same time step, with no clock edge in between.
- R8: A zero in either operand gives a zero product, and an operand of 1 passes the other operand through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 8 | Unsigned multiplicand |
| b | input | 8 | Unsigned multiplier; bit j selects partial-product row j |
| p | output | 16 | Full unsigned product |

## Verification
Every one of the 65,536 operand pairs is compared against a product computed in the bench. A wrong cell, a missing shift or a carry sent to the wrong column therefore shows up wherever it matters. Directed cases come first. One-hot multipliers isolate single partial-product rows and expose wrong row weights. All-ones operands drive the longest carry runs through every row and the final ripple adder. Alternating bit patterns such as 0xAA and 0x55 separate carries that go one column left from carries kept in place. Zero and unit operands separate the identity and annihilation cases from general products. A seeded random pass then applies operand changes without any clock edge, to confirm the product settles within the same time step.

// File: rtl/csa_mult_pkg.sv
package csa_mult_pkg;
  // Default operand width of the multiplier
  parameter int unsigned DEF_OPW = 8;

  // Product width for a given operand width
  function automatic int unsigned prod_width(input int unsigned opw);
    return 2 * opw;
  endfunction
endpackage

// File: rtl/csa_fa.sv
module csa_fa (
  input  logic x,
  input  logic y,
  input  logic z,
  output logic s,
  output logic co
);
  assign s  = x ^ y ^ z;
  assign co = (x & y) | (z & (x ^ y));

  // R3
  always_comb begin
    fa_count_chk: assert ({co, s} == (2'(x) + 2'(y) + 2'(z)))
      else $error("fa_count_chk: cell output does not count its inputs");
  end
endmodule

// File: rtl/csa_pp_matrix.sv
module csa_pp_matrix #(
  parameter int unsigned OPW = 8,
  localparam int unsigned PW = 2 * OPW
) (
  input  logic [OPW-1:0]    mcand,
  input  logic [OPW-1:0]    mplier,
  output logic [OPW*PW-1:0] rows
);
  for (genvar j = 0; j < OPW; j++) begin : g_row
    logic [PW-1:0] row;
    for (genvar k = 0; k < PW; k++) begin : g_col
      if (k >= j && k < j + OPW) begin : g_and
        assign row[k] = mcand[k-j] & mplier[j];
      end else begin : g_zero
        assign row[k] = 1'b0;
      end
    end
    assign rows[j*PW +: PW] = row;

    // R2
    always_comb begin
      if (!mplier[j]) begin
        pp_clear_row_chk: assert (row == '0)
          else $error("pp_clear_row_chk: row %0d nonzero with clear multiplier bit", j);
      end
    end
  end
endmodule

// File: rtl/csa_row.sv
module csa_row #(
  parameter int unsigned PW = 16
) (
  input  logic [PW-1:0] in_s,
  input  logic [PW-1:0] in_c,
  input  logic [PW-1:0] in_pp,
  output logic [PW-1:0] out_s,
  output logic [PW-1:0] out_c
);
  logic [PW-1:0] col_co;

  for (genvar k = 0; k < PW; k++) begin : g_cell
    csa_fa u_fa (
      .x (in_s[k]),
      .y (in_c[k]),
      .z (in_pp[k]),
      .s (out_s[k]),
      .co(col_co[k])
    );
  end

  // carry of column k moves to column k+1 for the next stage
  assign out_c = {col_co[PW-2:0], 1'b0};

  // R4
  always_comb begin
    row_conserve_chk: assert ((PW+2)'(in_s) + (PW+2)'(in_c) + (PW+2)'(in_pp)
                              == (PW+2)'(out_s) + ((PW+2)'(col_co) << 1))
      else $error("row_conserve_chk: carry-save row lost value");
    // R6
    row_top_carry_chk: assert (col_co[PW-1] == 1'b0)
      else $error("row_top_carry_chk: carry out of the top product column");
  end
endmodule

// File: rtl/csa_ripple_merge.sv
module csa_ripple_merge #(
  parameter int unsigned PW = 16
) (
  input  logic [PW-1:0] vs,
  input  logic [PW-1:0] vc,
  output logic [PW-1:0] total
);
  logic [PW:0] chain;
  assign chain[0] = 1'b0;

  for (genvar k = 0; k < PW; k++) begin : g_bit
    csa_fa u_fa (
      .x (vs[k]),
      .y (vc[k]),
      .z (chain[k]),
      .s (total[k]),
      .co(chain[k+1])
    );
  end

  // R5
  always_comb begin
    merge_sum_chk: assert ({chain[PW], total} == (PW+1)'(vs) + (PW+1)'(vc))
      else $error("merge_sum_chk: ripple merge total wrong");
    merge_no_cout_chk: assert (chain[PW] == 1'b0)
      else $error("merge_no_cout_chk: carry left the top of the merge adder");
  end
endmodule

// File: rtl/csa_array_mult.sv
module csa_array_mult #(
  parameter int unsigned OPW = csa_mult_pkg::DEF_OPW,
  localparam int unsigned PW = csa_mult_pkg::prod_width(OPW)
) (
  input  logic [OPW-1:0] a,
  input  logic [OPW-1:0] b,
  output logic [PW-1:0]  p
);
  localparam int unsigned NSTAGE = OPW - 1;

  logic [OPW*PW-1:0] pp_rows;
  logic [PW-1:0]     st_s [NSTAGE];
  logic [PW-1:0]     st_c [NSTAGE];

  csa_pp_matrix #(.OPW(OPW)) u_pp (
    .mcand (a),
    .mplier(b),
    .rows  (pp_rows)
  );

  // first stage takes the two lowest rows as the sum/carry pair
  assign st_s[0] = pp_rows[0 +: PW];
  assign st_c[0] = pp_rows[PW +: PW];

  for (genvar k = 1; k < NSTAGE; k++) begin : g_stage
    csa_row #(.PW(PW)) u_row (
      .in_s (st_s[k-1]),
      .in_c (st_c[k-1]),
      .in_pp(pp_rows[(k+1)*PW +: PW]),
      .out_s(st_s[k]),
      .out_c(st_c[k])
    );
  end

  csa_ripple_merge #(.PW(PW)) u_merge (
    .vs   (st_s[NSTAGE-1]),
    .vc   (st_c[NSTAGE-1]),
    .total(p)
  );

  // R1
  always_comb begin
    product_exact_chk: assert (p == PW'(a) * PW'(b))
      else $error("product_exact_chk: product differs from a*b");
  end
endmodule

// File: tb/sim_csa_array_mult.sv
module sim_csa_array_mult;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  a = '0;
  logic [7:0]  b = '0;
  logic [15:0] p;
  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  csa_array_mult #(.OPW(8)) u0 (.a(a), .b(b), .p(p));

  function automatic logic [15:0] ref_prod(input logic [7:0] x, input logic [7:0] y);
    return 16'(x) * 16'(y);
  endfunction

  task automatic check(input logic [7:0] x, input logic [7:0] y,
                       input logic [15:0] exp, input string tag);
    @(negedge clk);
    a = x;
    b = y;
    #5;
    n_cmp++;
    if (p !== exp) begin
      n_bad++;
      $display("FAIL %s: a=%0d b=%0d p=%h expected %h", tag, x, y, p, exp);
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    // R8 zero operands, including initial state
    check(8'd0, 8'd0, 16'h0000, "R8");
    check(8'd173, 8'd0, 16'h0000, "R8");
    check(8'd0, 8'd201, 16'h0000, "R8");
    check(8'd1, 8'd219, 16'd219, "R8");
    check(8'd77, 8'd1, 16'd77, "R8");
    // R6 full-width corners
    check(8'hFF, 8'hFF, 16'hFE01, "R6");
    check(8'hFF, 8'h01, 16'h00FF, "R6");
    // R2 one-hot multiplier rows
    for (int j = 0; j < 8; j++)
      check(8'hB5, 8'(1 << j), 16'(16'h00B5 << j), "R2");
    // R3 R4 R5 carry-heavy patterns
    check(8'hAA, 8'h55, 16'h3872, "R4");
    check(8'h55, 8'hAA, 16'h3872, "R4");
    check(8'hFF, 8'h80, 16'h7F80, "R5");
    check(8'h7F, 8'hFF, 16'h7E81, "R3");
    // R7 change operands with no clock edge between
    begin
      void'($urandom(32'd1234));
      for (int i = 0; i < 200; i++) begin
        logic [7:0] x;
        logic [7:0] y;
        x = 8'($urandom);
        y = 8'($urandom);
        @(posedge clk);
        #3;
        a = x;
        b = y;
        #1;
        n_cmp++;
        if (p !== ref_prod(x, y)) begin
          n_bad++;
          $display("FAIL R7: a=%0d b=%0d p=%h expected %h", x, y, p, ref_prod(x, y));
        end
      end
    end
    // R1 exhaustive sweep
    for (int x = 0; x < 256; x++)
      for (int y = 0; y < 256; y++)
        check(8'(x), 8'(y), ref_prod(8'(x), 8'(y)), "R1");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule